// File: doc/BRIEF.md
# Interrupt dispatch sequencer

This block sits between the interrupt request lines of a small 8-bit controller core and its instruction sequencer. It samples the active requests on every clock and picks a winner, first by a one-bit priority per source and then by source index. It registers that choice in a one-clock detect stage. When the core reports that an instruction has finished, the block decides whether to force a long call to the winner's vector.

Once a call is taken, the block pulses a call request for one clock and presents the vector address. It holds a busy flag for the four clocks of the call sequence and makes no new decision during that time. It also tracks which priority levels are in service. A new request is taken only when nothing is in service or when its level is above every level in service. The core marks the boundary of a return-from-interrupt with a flag. At that boundary the highest active level is released, and no call is taken, so one more instruction always runs first.

Execution, the stack and register saving all belong to the core. The sequencer only decides when to redirect the core and where to.

Top module: `intr_dispatch`

## Requirements
- R1: After reset, `vec_call` and `call_busy` are 0 and no priority level is in service, so the first eligible request of either level can be dispatched.
- R2: A request is picked up by the detect stage at the first clock edge that samples it. A call can start no earlier than the next edge, and only at an edge where `insn_end` is 1. With the core at a boundary on every clock, `call_busy` falls exactly 5 clocks after the sampling edge.
- R3: A call raises `call_busy` for exactly `CALL_CYCLES` (default 4) clocks. `vec_call` is 1 only in the first of those clocks. `insn_end` is ignored while `call_busy` is 1.
- R4: `vec_addr` equals `VEC_BASE + VEC_STRIDE * index`, which with the defaults is 0x0003 + 8 * index. It becomes valid with `vec_call` and holds while `call_busy` is 1.
- R5: A source whose `irq_prio_hi` bit is 1 beats every source whose bit is 0. Among sources of the same level, the lowest index wins.
- R6: A source is dispatched only if its `irq_req` bit is 1, its `irq_en` bit is 1 and `glb_en` is 1. A request held while masked or globally disabled is dispatched once it is enabled.
- R7: The in-service state has one bit for each of the two levels, and a level's bit is set when a call for that level starts. A low-level winner is taken only when no level is in service. A high-level winner is taken only when the high level is not in service.
- R8: A boundary with `reti_done` = 1 never starts a call and clears the highest in-service level only. The next ordinary boundary can then dispatch a request that was pending during the return.
- R9: A low-level request that arrives while a low-level routine runs is served at the latest 18 clocks after it is sampled. That case is one blocked boundary, then a 5-clock return and an 8-clock instruction, then the 4-clock call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Pending request per source (level) |
| irq_en | input | NUM_SRC | Per-source enable, 1 = may be dispatched |
| irq_prio_hi | input | NUM_SRC | Per-source level, 1 = high |
| glb_en | input | 1 | Global interrupt enable |
| insn_end | input | 1 | Core finishes an instruction in this clock |
| reti_done | input | 1 | The finishing instruction is a return-from-interrupt |
| vec_call | output | 1 | One-clock request to force a call |
| vec_addr | output | ADDR_W | Target vector of the call |
| call_busy | output | 1 | Forced call sequence in progress |

## Verification
Corrupted in-service bits show up at the next boundary where a request is pending. The port sequence then shows a nested call that should have been held back, or a held request that is never served, and the latest of these appears one full routine later. A wrong detect register or winner shows in `vec_addr` at the first pulse after the fault. A miscounting call counter stretches or shortens `call_busy` within that same call. The latency cases count clocks from the sampling edge to the fall of `call_busy`, so one extra register anywhere on the path shows as an off-by-one.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int NUM_LVL = 2;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    typedef logic [NUM_LVL-1:0] insvc_t;

endpackage

// File: rtl/intr_first_set.sv
module intr_first_set #(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] pos
);

    always_comb begin
        found = |vec;
        pos   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                pos = IW'(i);
            end
        end
    end

endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick
    import intr_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req_act,
    input  logic [NUM_SRC-1:0] prio_hi,
    output logic               valid,
    output lvl_e               lvl,
    output logic [IW-1:0]      idx
);

    logic [NUM_SRC-1:0] lvl_set [NUM_LVL];
    logic               lvl_fnd [NUM_LVL];
    logic [IW-1:0]      lvl_pos [NUM_LVL];

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        if (l == 1) begin : g_hi
            assign lvl_set[l] = req_act & prio_hi;
        end else begin : g_lo
            assign lvl_set[l] = req_act & ~prio_hi;
        end
        intr_first_set #(.W(NUM_SRC)) u_first (
            .vec   (lvl_set[l]),
            .found (lvl_fnd[l]),
            .pos   (lvl_pos[l])
        );
    end

    always_comb begin
        valid = lvl_fnd[1] | lvl_fnd[0];
        if (lvl_fnd[1]) begin
            lvl = LVL_HI;
            idx = lvl_pos[1];
        end else begin
            lvl = LVL_LO;
            idx = lvl_pos[0];
        end
    end

endmodule

// File: rtl/intr_insvc_track.sv
module intr_insvc_track
    import intr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   take,
    input  lvl_e   take_lvl,
    input  logic   ret,
    output insvc_t insvc
);

    typedef struct packed {
        insvc_t act;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (ret) begin
            if (trk_q.act[1]) begin
                trk_d.act[1] = 1'b0;
            end else begin
                trk_d.act[0] = 1'b0;
            end
        end else if (take) begin
            if (take_lvl == LVL_HI) begin
                trk_d.act[1] = 1'b1;
            end else begin
                trk_d.act[0] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign insvc = trk_q.act;

endmodule

// File: rtl/intr_call_seq.sv
module intr_call_seq #(
    parameter int NUM_SRC     = 8,
    parameter int ADDR_W      = 16,
    parameter int VEC_BASE    = 3,
    parameter int VEC_STRIDE  = 8,
    parameter int CALL_CYCLES = 4,
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CW = $clog2(CALL_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IW-1:0]     start_idx,
    output logic              vec_call,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              busy
);

    typedef struct packed {
        logic              busy;
        logic              pulse;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.pulse = 1'b0;
        if (start) begin
            seq_d.busy  = 1'b1;
            seq_d.pulse = 1'b1;
            seq_d.cnt   = '0;
            seq_d.addr  = ADDR_W'(VEC_BASE) + ADDR_W'(start_idx) * ADDR_W'(VEC_STRIDE);
        end else if (seq_q.busy) begin
            if (seq_q.cnt == CW'(CALL_CYCLES - 1)) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign vec_call = seq_q.pulse;
    assign vec_addr = seq_q.addr;
    assign busy     = seq_q.busy;

endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
    import intr_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int ADDR_W      = 16,
    parameter int VEC_BASE    = 3,
    parameter int VEC_STRIDE  = 8,
    parameter int CALL_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic [NUM_SRC-1:0] irq_prio_hi,
    input  logic               glb_en,
    input  logic               insn_end,
    input  logic               reti_done,
    output logic               vec_call,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               call_busy
);

    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic          valid;
        lvl_e          lvl;
        logic [IW-1:0] idx;
    } det_t;

    det_t               det_d, det_q;
    logic [NUM_SRC-1:0] req_act;
    logic               pk_valid;
    lvl_e               pk_lvl;
    logic [IW-1:0]      pk_idx;
    insvc_t             insvc;
    logic               lvl_ok;
    logic               take;
    logic               ret;

    intr_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req_act (req_act),
        .prio_hi (irq_prio_hi),
        .valid   (pk_valid),
        .lvl     (pk_lvl),
        .idx     (pk_idx)
    );

    always_comb begin
        req_act     = irq_req & irq_en & {NUM_SRC{glb_en}};
        det_d.valid = pk_valid;
        det_d.lvl   = pk_lvl;
        det_d.idx   = pk_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    always_comb begin
        if (det_q.lvl == LVL_HI) begin
            lvl_ok = ~insvc[1];
        end else begin
            lvl_ok = (insvc == '0);
        end
        take = det_q.valid && lvl_ok && insn_end && !reti_done && !call_busy;
        ret  = insn_end && reti_done && !call_busy;
    end

    intr_insvc_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_lvl (det_q.lvl),
        .ret      (ret),
        .insvc    (insvc)
    );

    intr_call_seq #(
        .NUM_SRC     (NUM_SRC),
        .ADDR_W      (ADDR_W),
        .VEC_BASE    (VEC_BASE),
        .VEC_STRIDE  (VEC_STRIDE),
        .CALL_CYCLES (CALL_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (take),
        .start_idx (det_q.idx),
        .vec_call  (vec_call),
        .vec_addr  (vec_addr),
        .busy      (call_busy)
    );

endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk #(
    parameter int NUM_SRC     = 8,
    parameter int ADDR_W      = 16,
    parameter int VEC_BASE    = 3,
    parameter int VEC_STRIDE  = 8,
    parameter int CALL_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en,
    input logic              insn_end,
    input logic              reti_done,
    input logic              vec_call,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              call_busy
);

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (call_busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        vec_call |-> call_busy); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_call |=> !vec_call); // R3
    AST_BUSY_OPENS_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_busy) |-> vec_call); // R3
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        call_busy |-> (run_q < CALL_CYCLES)); // R3
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(call_busy) |-> (run_q == CALL_CYCLES)); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (call_busy && !vec_call) |-> $stable(vec_addr)); // R4
    AST_ADDR_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        vec_call |-> ((int'(vec_addr) >= VEC_BASE)
                      && (((int'(vec_addr) - VEC_BASE) % VEC_STRIDE) == 0)
                      && (int'(vec_addr) < VEC_BASE + NUM_SRC * VEC_STRIDE))); // R4
    AST_CALL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        vec_call |-> $past(insn_end)); // R2
    AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_call |-> $past(glb_en, 2)); // R6
    AST_NO_CALL_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        vec_call |-> !$past(reti_done)); // R8

endmodule

bind intr_dispatch intr_dispatch_chk #(
    .NUM_SRC     (NUM_SRC),
    .ADDR_W      (ADDR_W),
    .VEC_BASE    (VEC_BASE),
    .VEC_STRIDE  (VEC_STRIDE),
    .CALL_CYCLES (CALL_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .insn_end  (insn_end),
    .reti_done (reti_done),
    .vec_call  (vec_call),
    .vec_addr  (vec_addr),
    .call_busy (call_busy)
);

// File: tb/sim_intr_dispatch.sv
module sim_intr_dispatch;

    localparam int N    = 8;
    localparam int BASE = 3;
    localparam int STEP = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_en = '0;
    logic [N-1:0] irq_prio_hi = '0;
    logic         glb_en = 1'b0;
    logic         insn_end = 1'b0;
    logic         reti_done = 1'b0;
    logic         vec_call;
    logic [15:0]  vec_addr;
    logic         call_busy;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    intr_dispatch u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .irq_prio_hi (irq_prio_hi),
        .glb_en      (glb_en),
        .insn_end    (insn_end),
        .reti_done   (reti_done),
        .vec_call    (vec_call),
        .vec_addr    (vec_addr),
        .call_busy   (call_busy)
    );

    task automatic check(bit ok, string tag, int act, int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp_v, cyc);
        end
    endtask

    function automatic bit ref_pick(logic [N-1:0] rq, logic [N-1:0] en, logic [N-1:0] hi,
                                    bit g, output int idx, output bit lvl);
        logic [N-1:0] act = rq & en & {N{g}};
        idx = 0;
        lvl = 1'b0;
        for (int l = 1; l >= 0; l--) begin
            for (int i = 0; i < N; i++) begin
                if (act[i] && (hi[i] == l[0])) begin
                    idx = i;
                    lvl = l[0];
                    return 1'b1;
                end
            end
        end
        return 1'b0;
    endfunction

    function automatic bit ref_ok(bit lvl, logic [1:0] ins);
        return lvl ? !ins[1] : (ins == 2'b00);
    endfunction

    task automatic drive(logic [N-1:0] rq, logic [N-1:0] en, logic [N-1:0] hi, bit g);
        irq_req     = rq;
        irq_en      = en;
        irq_prio_hi = hi;
        glb_en      = g;
    endtask

    task automatic run_insn(int len, bit ret);
        for (int i = 0; i < len; i++) begin
            insn_end  = (i == len - 1);
            reti_done = ret && (i == len - 1);
            @(negedge clk);
        end
        insn_end  = 1'b0;
        reti_done = 1'b0;
    endtask

    task automatic expect_call(bit exp_c, int idx, string tag);
        check(vec_call == exp_c, tag, int'(vec_call), int'(exp_c));
        check(call_busy == exp_c, tag, int'(call_busy), int'(exp_c));
        if (exp_c) begin
            check(int'(vec_addr) == BASE + STEP * idx, "R4 vector address", int'(vec_addr), BASE + STEP * idx);
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                check(call_busy == 1'b1, "R3 busy held", int'(call_busy), 1);
                check(vec_call == 1'b0, "R3 single pulse", int'(vec_call), 0);
            end
            @(negedge clk);
            check(call_busy == 1'b0, "R3 busy length", int'(call_busy), 0);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int t0;
        logic [1:0] ins_m;
        logic [N-1:0] r_req, r_en, r_hi;
        bit r_g, dirty;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        check(vec_call == 1'b0, "R1 reset vec_call", int'(vec_call), 0);
        check(call_busy == 1'b0, "R1 reset busy", int'(call_busy), 0);

        // R2 best-case latency, R3 boundary strobes ignored while busy
        drive(8'h08, 8'hFF, 8'h00, 1'b1);
        insn_end = 1'b1;
        t0 = cyc;
        @(negedge clk);
        check(call_busy == 1'b0, "R2 detect cycle", int'(call_busy), 0);
        @(negedge clk);
        check(vec_call == 1'b1, "R2 call after detect", int'(vec_call), 1);
        check(int'(vec_addr) == BASE + STEP * 3, "R4 address src3", int'(vec_addr), BASE + STEP * 3);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check(call_busy == 1'b1, "R3 busy with strobe high", int'(call_busy), 1);
            check(vec_call == 1'b0, "R3 no second pulse", int'(vec_call), 0);
        end
        insn_end = 1'b0;
        irq_req  = '0;
        @(negedge clk);
        check(call_busy == 1'b0, "R3 busy four clocks", int'(call_busy), 0);
        check(cyc - t0 - 1 == 5, "R2 best-case response", cyc - t0 - 1, 5);
        run_insn(1, 1'b1);
        expect_call(1'b0, 0, "R8 return clears low");

        // R5 high beats lower index low, R7 nesting, R8 return ordering
        drive(8'h46, 8'hFF, 8'hC0, 1'b1);
        run_insn(2, 1'b0);
        expect_call(1'b1, 6, "R5 high level wins");
        irq_req = 8'h06;
        run_insn(3, 1'b0);
        expect_call(1'b0, 0, "R7 low blocked by high");
        run_insn(2, 1'b1);
        expect_call(1'b0, 0, "R8 no call at return");
        run_insn(2, 1'b0);
        expect_call(1'b1, 1, "R5 lowest index tie");
        irq_req = 8'h04;
        run_insn(2, 1'b0);
        expect_call(1'b0, 0, "R7 low blocked by low");
        irq_req = 8'h84;
        run_insn(2, 1'b0);
        expect_call(1'b1, 7, "R7 high nests over low");
        irq_req = 8'h04;
        run_insn(2, 1'b1);
        expect_call(1'b0, 0, "R8 return clears high only");
        run_insn(2, 1'b0);
        expect_call(1'b0, 0, "R8 low still in service");
        run_insn(2, 1'b1);
        expect_call(1'b0, 0, "R8 no call at return");
        run_insn(1, 1'b0);
        expect_call(1'b1, 2, "R8 next boundary dispatches");
        irq_req = '0;
        run_insn(2, 1'b1);
        expect_call(1'b0, 0, "R8 return");

        // R6 masking and global enable
        drive(8'h10, 8'hEF, 8'h00, 1'b1);
        run_insn(3, 1'b0);
        expect_call(1'b0, 0, "R6 source masked");
        drive(8'h10, 8'hFF, 8'h00, 1'b0);
        run_insn(3, 1'b0);
        expect_call(1'b0, 0, "R6 global disabled");
        glb_en = 1'b1;
        run_insn(2, 1'b0);
        expect_call(1'b1, 4, "R6 held request dispatched");
        irq_req = '0;
        run_insn(2, 1'b1);
        expect_call(1'b0, 0, "R8 return");

        // R9 worst-case response: blocked boundary, return, 8-clock instruction
        irq_req = 8'h01;
        run_insn(2, 1'b0);
        expect_call(1'b1, 0, "R7 low taken when idle");
        irq_req = 8'h20;
        t0 = cyc;
        run_insn(2, 1'b0);
        expect_call(1'b0, 0, "R9 blocked boundary");
        run_insn(5, 1'b1);
        expect_call(1'b0, 0, "R9 return boundary");
        run_insn(8, 1'b0);
        expect_call(1'b1, 5, "R9 call after long instruction");
        check(cyc - t0 - 1 == 18, "R9 worst-case response", cyc - t0 - 1, 18);
        irq_req = '0;
        run_insn(2, 1'b1);
        expect_call(1'b0, 0, "R8 return");

        // Constrained random: R5/R6/R7/R8 against the bench model
        ins_m = 2'b00;
        r_req = '0;
        r_en  = 8'hFF;
        r_hi  = '0;
        r_g   = 1'b1;
        dirty = 1'b0;
        for (int it = 0; it < 400; it++) begin
            int len, w_idx;
            bit chg, ret, w_lvl, exp_c;
            chg = (($urandom % 3) != 0) || dirty;
            if (chg) begin
                r_req = r_req | (8'($urandom) & 8'($urandom));
                r_en  = 8'($urandom) | 8'($urandom);
                r_hi  = 8'($urandom) & 8'($urandom);
                r_g   = (($urandom % 6) != 0);
            end
            len = chg ? 2 + int'($urandom % 7) : 1 + int'($urandom % 8);
            ret = (ins_m != 2'b00) ? (($urandom % 3) == 0) : (($urandom % 12) == 0);
            drive(r_req, r_en, r_hi, r_g);
            dirty = 1'b0;
            run_insn(len, ret);
            w_idx = 0;
            w_lvl = 1'b0;
            exp_c = 1'b0;
            if (ret) begin
                if (ins_m[1]) ins_m[1] = 1'b0;
                else ins_m[0] = 1'b0;
            end else if (ref_pick(r_req, r_en, r_hi, r_g, w_idx, w_lvl)) begin
                exp_c = ref_ok(w_lvl, ins_m);
                if (exp_c) begin
                    ins_m[w_lvl] = 1'b1;
                    r_req[w_idx] = 1'b0;
                    dirty = 1'b1;
                end
            end
            expect_call(exp_c, w_idx, ret ? "R8 random return" : "R7 random dispatch");
        end

        finish_run();
    end

endmodule